// File: doc/BRIEF.md
# EEPROM Page Write Buffer and Timed Commit Controller

This block sits between a two-wire serial protocol engine and the byte array of a small serial EEPROM. The engine hands it each received data byte as a strobe that carries the page number and the column inside the page. The block gathers these bytes in a one-page staging buffer. Each buffer column has its own valid bit, so a transaction can supply any number of bytes from one to a full page.

When the engine reports a STOP, the block checks two things: that the transaction carried at least one data byte, and that the hardware write-protect input is low. If both hold, it raises `busy` and starts an internal write cycle whose length is set by a parameter in system clocks. During the first cycles of that window it copies only the marked columns into the array, one column per clock, through a single write port. A written byte simply replaces the old one, so no separate erase step exists. While `busy` is high the block ignores every strobe, which lets the protocol engine withhold acknowledges. An abort strobe (the engine's report of a repeated START or a broken transaction) discards the staged bytes. A STOP while write-protect is high also discards them. A registered read port serves the protocol engine's reads at all times, whatever the state of write-protect.

Top module: `eeprom_page_writer`

## Requirements
- R1: After a committed transaction, each column that received a byte holds that byte at array address {page, column}; every other column of the page and every other page keeps its old value.
- R2: If one column is strobed several times within a transaction, the array receives the value from the last of those strobes.
- R3: A STOP sampled while idle, with write-protect low and at least one buffered byte, makes `busy` high from the next clock for exactly WRITE_CYCLES cycles (WRITE_CYCLES must exceed the page size); the new data is readable once `busy` is low.
- R4: A STOP sampled while idle with no buffered byte leaves `busy` low and the array unchanged.
- R5: While `busy` is high, byte, STOP and abort strobes have no effect: no byte is staged, the write window is neither shortened nor restarted, and no array content changes.
- R6: A STOP sampled while write-protect is high leaves `busy` low and the array unchanged, and discards the staged bytes, so a following STOP with write-protect low and no new bytes starts no write cycle.
- R7: Reads return array contents unchanged while write-protect is high.
- R8: An abort strobe sampled while idle discards the staged bytes: a following STOP starts no write cycle, and a later transaction commits only its own bytes.
- R9: When `busy` falls, the buffer is empty, so a bare STOP right afterwards starts no write cycle.
- R10: `rd_data` shows the array byte at `rd_addr` sampled on the previous clock edge. After reset `busy` and `rd_data` are 0, and the array starts all zero.
- R11: The page of a commit is the page carried by the last byte strobe of the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe | input | 1 | One received data byte is present |
| wr_page | input | PAGE_W | Page number of the byte |
| wr_col | input | COL_W | Column of the byte inside its page |
| wr_data | input | DATA_W | Byte value |
| stop_strobe | input | 1 | STOP ended the current transaction |
| abort_strobe | input | 1 | Transaction ended without STOP (repeated START or abort) |
| wp | input | 1 | Hardware write protect, high protects the whole array |
| rd_addr | input | PAGE_W+COL_W | Read address {page, column} |
| rd_data | output | DATA_W | Registered read data |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The bound checker watches, on every clock, how long each busy window lasts, that a qualifying STOP starts a window, and that empty or protected STOPs start none. It also checks that aborts and finished windows leave the buffer empty, and that staged bytes stay frozen while busy. Only the bench scenarios can show what actually lands in the array: which columns change, last-write-wins within one column, the page taken from the last strobe, the byte rejected during busy, and reads under write protect. These need a full model of the array that is read back through the read port.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  // How the transaction in flight is closed this cycle.
  typedef enum logic [1:0] {
    END_NONE   = 2'd0,
    END_COMMIT = 2'd1,
    END_DROP   = 2'd2
  } txn_end_e;
endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int DATA_W = 8,
  parameter int COL_W  = 4,
  parameter int PAGE_W = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cap_en,
  input  logic [COL_W-1:0]          cap_col,
  input  logic [PAGE_W-1:0]         cap_page,
  input  logic [DATA_W-1:0]         cap_data,
  input  logic                      clear,
  input  logic [COL_W-1:0]          sel_col,
  output logic [(1<<COL_W)-1:0]     vld_mask,
  output logic [PAGE_W-1:0]         page_q,
  output logic [DATA_W-1:0]         sel_byte
);
  localparam int PAGE_BYTES = 1 << COL_W;

  logic [DATA_W-1:0] col_q [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_col
    logic hit;
    assign hit = cap_en && (cap_col == COL_W'(g));

    always_ff @(posedge clk) begin
      if (hit) col_q[g] <= cap_data;
    end

    always_ff @(posedge clk) begin
      if (rst || clear)  vld_mask[g] <= 1'b0;
      else if (hit)      vld_mask[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         page_q <= '0;
    else if (cap_en) page_q <= cap_page;
  end

  assign sel_byte = col_q[sel_col];
endmodule

// File: rtl/pgw_write_timer.sv
module pgw_write_timer #(
  parameter int CYCLES = 625000,
  parameter int STEP_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              done
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(CYCLES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
    end else if (!busy) begin
      step <= '0;
      if (start) busy <= 1'b1;
    end else if (step == LAST) begin
      busy <= 1'b0;
      step <= '0;
    end else begin
      step <= step + 1'b1;
    end
  end

  assign done = busy && (step == LAST);
endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import pgw_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int COL_W        = 4,
  parameter int PAGE_W       = 7,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_strobe,
  input  logic [PAGE_W-1:0]       wr_page,
  input  logic [COL_W-1:0]        wr_col,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    stop_strobe,
  input  logic                    abort_strobe,
  input  logic                    wp,
  input  logic [PAGE_W+COL_W-1:0] rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    busy
);
  localparam int PAGE_BYTES = 1 << COL_W;
  localparam int ADDR_W     = PAGE_W + COL_W;
  localparam int STEP_W     = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;

  if (WRITE_CYCLES <= PAGE_BYTES) begin : g_bad_cycles
    $error("WRITE_CYCLES must exceed the page size");
  end

  logic [PAGE_BYTES-1:0] vld_mask;
  logic [PAGE_W-1:0]     page_q;
  logic [DATA_W-1:0]     sel_byte;
  logic [STEP_W-1:0]     step;
  logic                  done;
  logic                  cap_en;
  logic                  buf_clear;
  logic [COL_W-1:0]      commit_col;
  logic                  arr_we;
  txn_end_e              end_kind;

  always_comb begin
    end_kind = END_NONE;
    if (!busy) begin
      if (abort_strobe)
        end_kind = END_DROP;
      else if (stop_strobe)
        end_kind = (!wp && (|vld_mask)) ? END_COMMIT : END_DROP;
    end
  end

  assign cap_en    = wr_strobe && !busy && !stop_strobe && !abort_strobe;
  assign buf_clear = (end_kind == END_DROP) || done;

  pgw_page_buf #(
    .DATA_W (DATA_W),
    .COL_W  (COL_W),
    .PAGE_W (PAGE_W)
  ) buf_i (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .cap_col  (wr_col),
    .cap_page (wr_page),
    .cap_data (wr_data),
    .clear    (buf_clear),
    .sel_col  (commit_col),
    .vld_mask (vld_mask),
    .page_q   (page_q),
    .sel_byte (sel_byte)
  );

  pgw_write_timer #(
    .CYCLES (WRITE_CYCLES),
    .STEP_W (STEP_W)
  ) tmr_i (
    .clk   (clk),
    .rst   (rst),
    .start (end_kind == END_COMMIT),
    .busy  (busy),
    .step  (step),
    .done  (done)
  );

  // First PAGE_BYTES steps of the window walk the columns.
  assign commit_col = step[COL_W-1:0];
  assign arr_we     = busy && (step < STEP_W'(PAGE_BYTES)) && vld_mask[commit_col];

  pgw_array #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) arr_i (
    .clk   (clk),
    .rst   (rst),
    .we    (arr_we),
    .waddr ({page_q, commit_col}),
    .wdata (sel_byte),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int COL_W        = 4,
  parameter int WRITE_CYCLES = 625000
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  stop_strobe,
  input logic                  abort_strobe,
  input logic                  wp,
  input logic                  busy,
  input logic [(1<<COL_W)-1:0] vld_mask
);
  localparam int RUN_W = $clog2(WRITE_CYCLES + 2);

  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_len == RUN_W'(WRITE_CYCLES));

  p_busy_start_r3: assert property (@(posedge clk) disable iff (rst)
    (stop_strobe && !abort_strobe && !busy && !wp && vld_mask != '0) |=> busy);

  p_empty_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (stop_strobe && !busy && vld_mask == '0) |=> !busy);

  p_frozen_buf_r5: assert property (@(posedge clk) disable iff (rst)
    busy |=> (vld_mask == $past(vld_mask)) || (vld_mask == '0));

  p_wp_block_r6: assert property (@(posedge clk) disable iff (rst)
    (stop_strobe && wp && !busy) |=> (!busy && vld_mask == '0));

  p_abort_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (abort_strobe && !busy) |=> vld_mask == '0);

  p_empty_after_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> vld_mask == '0);
endmodule

bind eeprom_page_writer pgw_checker #(
  .COL_W        (COL_W),
  .WRITE_CYCLES (WRITE_CYCLES)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .stop_strobe  (stop_strobe),
  .abort_strobe (abort_strobe),
  .wp           (wp),
  .busy         (busy),
  .vld_mask     (vld_mask)
);

// File: tb/eeprom_page_writer_tb_top.sv
module eeprom_page_writer_tb_top;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int PW = 3;
  localparam int NC = 24;
  localparam int PB = 1 << CW;
  localparam int NPAGE = 1 << PW;
  localparam int DEPTH = NPAGE * PB;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          wr_strobe = 1'b0;
  logic [PW-1:0] wr_page = '0;
  logic [CW-1:0] wr_col = '0;
  logic [DW-1:0] wr_data = '0;
  logic          stop_strobe = 1'b0;
  logic          abort_strobe = 1'b0;
  logic          wp = 1'b0;
  logic [PW+CW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          busy;

  eeprom_page_writer #(
    .DATA_W (DW), .COL_W (CW), .PAGE_W (PW), .WRITE_CYCLES (NC)
  ) dut_i (
    .clk (clk), .rst (rst), .wr_strobe (wr_strobe), .wr_page (wr_page),
    .wr_col (wr_col), .wr_data (wr_data), .stop_strobe (stop_strobe),
    .abort_strobe (abort_strobe), .wp (wp), .rd_addr (rd_addr),
    .rd_data (rd_data), .busy (busy)
  );

  logic [DW-1:0] model [DEPTH];
  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_byte(input int p, input int c, input int d);
    wr_strobe = 1'b1; wr_page = PW'(p); wr_col = CW'(c); wr_data = DW'(d);
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_strobe = 1'b1; @(negedge clk); stop_strobe = 1'b0;
  endtask

  task automatic pulse_abort();
    abort_strobe = 1'b1; @(negedge clk); abort_strobe = 1'b0;
  endtask

  task automatic expect_window(input int exp_len, input string tag);
    int n = 0;
    while (busy && n < NC + 8) begin
      n++;
      @(negedge clk);
    end
    check(n == exp_len, tag, n, exp_len);
  endtask

  task automatic expect_idle(input string tag);
    int seen = 0;
    repeat (4) begin
      if (busy) seen++;
      @(negedge clk);
    end
    check(seen == 0, tag, seen, 0);
  endtask

  task automatic check_page(input int p, input string tag);
    for (int c = 0; c < PB; c++) begin
      rd_addr = (PW+CW)'(p * PB + c);
      @(negedge clk);
      check(rd_data == model[p * PB + c], tag, int'(rd_data), int'(model[p * PB + c]));
    end
  endtask

  initial begin
    repeat (NC * 6000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
    check(rd_data == '0, "R10 rd_data after reset", int'(rd_data), 0);
    check_page(0, "R10 zero array");

    // R1/R3: sweep every page with varying column subsets, two rounds
    for (int r = 0; r < 2; r++) begin
      for (int p = 0; p < NPAGE; p++) begin
        for (int c = 0; c < PB; c++) begin
          if (((c * 3 + p + r) % 5 == 0) || (c == (p + r) % PB)) begin
            int d = (p * 37 + c * 11 + r * 101 + 90) & 255;
            put_byte(p, c, d);
            model[p * PB + c] = DW'(d);
          end
        end
        pulse_stop();
        expect_window(NC, "R3 busy length");
        check_page(p, "R1 partial page");
      end
    end
    for (int p = 0; p < NPAGE; p++) check_page(p, "R1 other pages intact");

    // R2: last write to a column wins
    put_byte(1, 3, 8'h11); put_byte(1, 3, 8'h22); put_byte(1, 9, 8'h44); put_byte(1, 3, 8'h33);
    model[1 * PB + 3] = 8'h33; model[1 * PB + 9] = 8'h44;
    pulse_stop();
    expect_window(NC, "R2 busy length");
    check_page(1, "R2 last write wins");

    // R4: empty STOP
    pulse_stop();
    expect_idle("R4 empty stop no busy");
    check_page(1, "R4 array unchanged");

    // R6/R7: write protect
    wp = 1'b1;
    put_byte(4, 0, 8'hE1); put_byte(4, 7, 8'hE2);
    pulse_stop();
    expect_idle("R6 protected stop no busy");
    check_page(4, "R7 reads under protect");
    wp = 1'b0;
    pulse_stop();
    expect_idle("R6 protected bytes discarded");
    check_page(4, "R6 array unchanged");

    // R8: abort discards
    put_byte(6, 2, 8'hC1); put_byte(6, 5, 8'hC2);
    pulse_abort();
    pulse_stop();
    expect_idle("R8 stop after abort no busy");
    check_page(6, "R8 array unchanged after abort");
    put_byte(6, 11, 8'hC3);
    model[6 * PB + 11] = 8'hC3;
    pulse_stop();
    expect_window(NC, "R8 new transaction busy");
    check_page(6, "R8 only new bytes committed");

    // R5/R9: strobes during busy ignored, window not restarted
    put_byte(3, 4, 8'h9A);
    model[3 * PB + 4] = 8'h9A;
    pulse_stop();
    check(busy == 1'b1, "R5 busy at start", int'(busy), 1);
    put_byte(3, 12, 8'h5F);
    check(busy == 1'b1, "R5 busy during strobe", int'(busy), 1);
    pulse_abort();
    pulse_stop();
    expect_window(NC - 3, "R5 window not restarted");
    pulse_stop();
    expect_idle("R9 buffer empty after commit");
    check_page(3, "R5 ignored byte not written");

    // R11: page from last strobe
    put_byte(2, 1, 8'hAA); put_byte(5, 2, 8'hBB);
    model[5 * PB + 1] = 8'hAA; model[5 * PB + 2] = 8'hBB;
    pulse_stop();
    expect_window(NC, "R11 busy length");
    check_page(5, "R11 bytes in last page");
    check_page(2, "R11 first page untouched");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule